// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

The block adds two unsigned words one bit position per clock. One full adder and a carry flip-flop handle the arithmetic. The first operand sits in an accumulator shift register and the second sits in an addend shift register. On each shift cycle the adder combines the two low bits with the stored carry. The sum bit enters the accumulator from the top, so the result overwrites the first operand in place. The addend register rotates its low bit back into its top bit, so it holds its original value when the operation ends.

A small step controller starts an addition when `start` is seen while it is idle. It then produces exactly WIDTH shift cycles. The first shift happens on the same edge that samples `start`. While the controller is idle, either register can be loaded in parallel, and any load clears the carry. A start issued without a fresh load adds the unchanged addend to the accumulator again. In that case the carry left by the previous addition is the carry-in.

Top module: `serial_acc_adder`

## Requirements
- R1: While reset is asserted and after it is released, acc_out is 0, carry_out is 0, busy is 0, done is 0 and the addend register holds 0.
- R2: When load_acc (or load_add) is 1 at a clock edge where no shift occurs, the accumulator (or addend) takes acc_in (or add_in) at that edge and carry_out becomes 0.
- R3: start=1 at an edge while idle begins an addition with a shift on that same edge. Exactly WIDTH shifts occur on consecutive edges. busy is 1 for the WIDTH-1 cycles after the start edge and 0 otherwise.
- R4: Let A, B and c be the accumulator, addend and carry before the start edge. After the last shift, acc_out equals (A+B+c) mod 2^WIDTH and carry_out equals bit WIDTH of A+B+c.
- R5: After an addition the addend register holds its pre-start value. A following start with no load adds the same addend again.
- R6: done is 1 for exactly one cycle, in the cycle after the edge of the last shift, and is 0 at all other times.
- R7: load_acc, load_add and start are ignored at any edge where a shift occurs. This includes a load in the same cycle as an accepted start: that addition uses the old operands and the old carry.
- R8: A start with no load since the previous addition uses that addition's final carry as its carry-in.
- R9: With WIDTH=4, loading 0101 and 0111 and then adding gives acc_out=1100 and carry_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an addition when the controller is idle |
| load_acc | input | 1 | Parallel load of the accumulator, clears the carry |
| acc_in | input | WIDTH | Value for the accumulator load |
| load_add | input | 1 | Parallel load of the addend, clears the carry |
| add_in | input | WIDTH | Value for the addend load |
| acc_out | output | WIDTH | Accumulator contents, holds the sum after an addition |
| carry_out | output | 1 | Carry flip-flop, holds the final carry after an addition |
| busy | output | 1 | Controller is in one of its shift steps past the first |
| done | output | 1 | One-cycle pulse after the last shift |

## Verification
Operand loading and the start of an addition can fall in the same cycle. Both write the accumulator and the carry, and the block resolves the collision in favour of the shift. The bench provokes this by raising load_acc or load_add with random values in the start cycle, and also in cycles of a running addition. It then compares the final sum and carry with a model that keeps the old operands and carry. A load that slipped in would change the result or zero the carry, and the comparison reports either difference.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    // result of one full-adder evaluation
    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

endpackage

// File: rtl/sacc_full_adder.sv
module sacc_full_adder
    import sacc_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    cin,
    output fa_out_t res
);

    always_comb begin
        res.sum  = a ^ b ^ cin;
        res.cout = (a & b) | (a & cin) | (b & cin);
    end

endmodule

// File: rtl/sacc_shift_reg.sv
module sacc_shift_reg #(
    parameter int WIDTH  = 4,
    parameter bit ROTATE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] word_d, word_q;
    logic             top_bit;

    generate
        if (ROTATE) begin : g_rot
            assign top_bit = word_q[0];
        end else begin : g_ser
            assign top_bit = ser_in;
        end
    endgenerate

    always_comb begin
        word_d = word_q;
        if (shift) begin
            word_d = {top_bit, word_q[WIDTH-1:1]};
        end else if (load) begin
            word_d = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign q = word_q;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !shift) |=> (q == $past(load_val)));

    // R3
    shift_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));

    generate
        if (ROTATE) begin : g_rot_chk
            // R5
            rotate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                shift |=> ($countones(q) == $countones($past(q))));
        end
    endgenerate

endmodule

// File: rtl/sacc_ctrl.sv
module sacc_ctrl #(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic shift,
    output logic busy,
    output logic done
);

    localparam int CW = (STEPS > 2) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic [CW-1:0] step;
        logic          done;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     shift_c;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        shift_c   = 1'b0;
        if (st_q.step == '0) begin
            if (start) begin
                shift_c   = 1'b1;
                st_d.step = CW'(1);
            end
        end else begin
            shift_c = 1'b1;
            if (st_q.step == LAST) begin
                st_d.step = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift = shift_c;
    assign busy  = (st_q.step != '0);
    assign done  = st_q.done;

    // R3
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.step != LAST) |=> busy);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder
    import sacc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load_acc,
    input  logic [WIDTH-1:0] acc_in,
    input  logic             load_add,
    input  logic [WIDTH-1:0] add_in,
    output logic [WIDTH-1:0] acc_out,
    output logic             carry_out,
    output logic             busy,
    output logic             done
);

    logic             shift;
    logic [WIDTH-1:0] acc_q, add_q;
    fa_out_t          fa;
    logic             carry_d, carry_q;

    sacc_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .shift (shift),
        .busy  (busy),
        .done  (done)
    );

    sacc_full_adder u_fa (
        .a   (acc_q[0]),
        .b   (add_q[0]),
        .cin (carry_q),
        .res (fa)
    );

    sacc_shift_reg #(.WIDTH(WIDTH), .ROTATE(1'b0)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_acc),
        .load_val (acc_in),
        .shift    (shift),
        .ser_in   (fa.sum),
        .q        (acc_q)
    );

    sacc_shift_reg #(.WIDTH(WIDTH), .ROTATE(1'b1)) u_add (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_add),
        .load_val (add_in),
        .shift    (shift),
        .ser_in   (1'b0),
        .q        (add_q)
    );

    always_comb begin
        carry_d = carry_q;
        if (shift)                     carry_d = fa.cout;
        else if (load_acc || load_add) carry_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
    end

    assign acc_out   = acc_q;
    assign carry_out = carry_q;

    // R2
    load_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((load_acc || load_add) && !shift) |=> !carry_out);

    // R7
    idle_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load_acc && !load_add) |=> $stable(carry_out));

endmodule

// File: tb/sim_serial_acc_adder.sv
`timescale 1ns/1ps
module sim_serial_acc_adder;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         load_acc = 1'b0;
    logic [W-1:0] acc_in = '0;
    logic         load_add = 1'b0;
    logic [W-1:0] add_in = '0;
    logic [W-1:0] acc_out;
    logic         carry_out, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [W-1:0] m_acc, m_add;
    logic         m_c;

    always #2.5 clk = ~clk;

    serial_acc_adder #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_acc(load_acc), .acc_in(acc_in),
        .load_add(load_add), .add_in(add_in),
        .acc_out(acc_out), .carry_out(carry_out),
        .busy(busy), .done(done)
    );

    function automatic logic [W:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(logic la, logic [W-1:0] va, logic lb, logic [W-1:0] vb);
        load_acc = la; acc_in = va; load_add = lb; add_in = vb;
        @(negedge clk);
        load_acc = 1'b0; load_add = 1'b0;
        if (la) m_acc = va;
        if (lb) m_add = vb;
        m_c = 1'b0;
        chk("R2 acc", acc_out, m_acc);
        chk("R2 carry", carry_out, 1'b0);
    endtask

    // mode 0 plain, 1 load with start, 2 load and start during run
    task automatic do_add(int mode, string req);
        logic [W:0] r;
        r = ref_sum(m_acc, m_add, m_c);
        start = 1'b1;
        if (mode == 1) begin
            load_acc = 1'b1; acc_in = W'($urandom);
            load_add = 1'b1; add_in = W'($urandom);
        end
        @(negedge clk);
        start = 1'b0; load_acc = 1'b0; load_add = 1'b0;
        for (int i = 1; i < W; i++) begin
            chk("R3 busy", busy, 1'b1);
            chk("R6 no early done", done, 1'b0);
            if (mode == 2) begin
                start = 1'b1;
                load_acc = 1'b1; acc_in = W'($urandom);
                load_add = 1'b1; add_in = W'($urandom);
            end
            @(negedge clk);
            start = 1'b0; load_acc = 1'b0; load_add = 1'b0;
        end
        m_acc = r[W-1:0];
        m_c = r[W];
        chk({req, " sum"}, acc_out, m_acc);
        chk({req, " carry"}, carry_out, m_c);
        chk("R3 busy end", busy, 1'b0);
        chk("R6 done", done, 1'b1);
        @(negedge clk);
        chk("R6 done one cycle", done, 1'b0);
        chk("R3 no extra shift", acc_out, m_acc);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        m_acc = '0; m_add = '0; m_c = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 acc", acc_out, '0);
        chk("R1 busy", busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 carry", carry_out, 1'b0);
        chk("R1 done", done, 1'b0);
        // R1 addend zero: adding keeps acc zero
        do_add(0, "R1 addend zero");

        // R9 directed example
        do_load(1'b1, 4'b0101, 1'b1, 4'b0111);
        do_add(0, "R9");
        chk("R9 value", acc_out, 4'b1100);

        // R4 overflow corner: 1111 + 0001
        do_load(1'b1, 4'hF, 1'b1, 4'h1);
        do_add(0, "R4 wrap");
        // R8 carry from previous seeds next add; R5 addend kept
        do_add(0, "R8 carry chain");
        do_add(0, "R5 addend reuse");

        // R7 load in same cycle as start
        do_load(1'b1, 4'hA, 1'b1, 4'h9);
        do_add(1, "R7 load at start");
        // R7 loads and start during run
        do_add(2, "R7 load while busy");

        // R4 all-ones
        do_load(1'b1, 4'hF, 1'b1, 4'hF);
        do_add(0, "R4 max");

        for (int n = 0; n < 60; n++) begin
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0) do_load(1'b1, W'($urandom), 1'b1, W'($urandom));
            else if (sel == 1) do_load(1'b1, W'($urandom), 1'b0, '0);
            do_add(int'($urandom % 3), "R4 random");
            if (($urandom % 3) == 0) begin
                @(negedge clk);
                chk("R7 idle hold", acc_out, m_acc);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule